// File: doc/BRIEF.md
# Graphic LCD Start-up Sequencer

This block brings a dot-matrix graphic LCD controller out of power-up without any processor involvement. When the chip reset is released, it holds the panel's active-low reset pin low for a configurable number of clock cycles. It then releases the pin and waits the same number of cycles for the panel to settle. After that it programs the controller through an external register-write engine, one write at a time.

The first five writes carry values derived from the display geometry parameters. These are the mode bits, the character cell size, the number of character columns, the multiplex duty and the cursor line. Each size value is sent as the count minus one. Four writes of zero follow, which move the display start address and the cursor address to the origin. Finally, the block streams the bytes of a small built-in message to the data-write register, stopping at the first `=` character. A done flag then rises and stays high.

Each write is a request/done handshake. The block raises a request together with a 4-bit register number and an 8-bit value, and holds all three until the engine returns a one-cycle done pulse. How the engine times the bus transfer is its own concern.

Top module: `lcd_startup_seq`

## Requirements
- R1: `panelRstN` is low while `rstN` is low. It stays low for exactly `DELAY_CYCLES` rising clock edges after `rstN` is released, then goes high and never falls again until the next reset.
- R2: The first `wrReq` rises `DELAY_CYCLES` edges after `panelRstN` rises, so `2*DELAY_CYCLES` edges after reset release. `wrReq` is never high while `panelRstN` is low.
- R3: Once raised, `wrReq` stays high with `wrReg` and `wrVal` unchanged until `wrDone` is sampled high. `wrReq` is low on the next edge. The next request rises on the edge after that, two edges after the done pulse.
- R4: The register numbers are written in this order: 0, 1, 2, 3, 4, 8, 9, 10, 11, then 12 for every message byte.
- R5: The value written to register 0 is built from six mode-bit parameters: bit 5 display on, bit 4 master, bit 3 cursor blink, bit 2 cursor shown, bit 1 graphics mode, bit 0 external character generator. Bits 7:6 are zero.
- R6: The value written to register 1 is `CHAR_H-1` in bits 7:4 and `CHAR_W-1` in bits 3:0.
- R7: Register 2 receives `DISP_W/CHAR_W-1`, register 3 receives `DUTY-1` and register 4 receives `CURSOR_LINE-1`.
- R8: Registers 8, 9, 10 and 11 each receive 0x00.
- R9: Message bytes go to register 12 in order, starting at byte 0 (the leftmost character of `MSG`). The first byte equal to 0x3D (`=`) ends the stream and is not written, and neither is any byte after it.
- R10: `seqDone` rises two edges after the done pulse of the last write. It then stays high, and no further request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| panelRstN | output | 1 | Active-low reset to the LCD panel |
| wrReq | output | 1 | Register write request to the write engine |
| wrReg | output | 4 | Register number of the current write |
| wrVal | output | 8 | Value of the current write |
| wrDone | input | 1 | One-cycle pulse from the engine: current write finished |
| seqDone | output | 1 | Sequence complete, sticky until reset |

## Verification
The bench keeps a count of rising edges since reset release. It samples every output on falling edges, so each event gets an exact edge number. The reset release must appear at edge `DELAY_CYCLES` and the first request at edge `2*DELAY_CYCLES`. Each later request must appear two edges after the bench drove the previous done pulse, and `seqDone` two edges after the final one. The engine model varies its response delay from zero to three cycles per write, so the hold-until-done rule is exercised with done pulses at different times. Two geometry and message configurations are run, and the full write log of each is compared with a list computed arithmetically from its parameters.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  // Register numbers decoded by the panel controller
  localparam logic [3:0] REG_MODE    = 4'd0;
  localparam logic [3:0] REG_PITCH   = 4'd1;
  localparam logic [3:0] REG_COLS    = 4'd2;
  localparam logic [3:0] REG_DUTY    = 4'd3;
  localparam logic [3:0] REG_CURLINE = 4'd4;
  localparam logic [3:0] REG_HOME0   = 4'd8;
  localparam logic [3:0] REG_TEXT    = 4'd12;

  localparam int         CFG_WRITES  = 9;
  localparam logic [7:0] TERM_CHAR   = 8'h3D;

  typedef struct packed {
    logic cntClr;
    logic stepAdv;
    logic charAdv;
  } seqStrobe_t;

  typedef struct packed {
    logic delayHit;
    logic cfgDone;
    logic charIsTerm;
  } seqStatus_t;

endpackage

// File: rtl/lcd_seq_ctrl.sv
module lcd_seq_ctrl
  import lcd_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrDone,
  input  seqStatus_t status,
  output seqStrobe_t strobe,
  output logic       panelRstN,
  output logic       wrReq,
  output logic       seqDone
);

  typedef enum logic [2:0] {
    ST_PANEL_LOW,
    ST_SETTLE,
    ST_ISSUE,
    ST_ADVANCE,
    ST_FINISHED
  } seqState_t;

  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_PANEL_LOW;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_PANEL_LOW: begin
        if (status.delayHit) begin
          strobe.cntClr = 1'b1;
          nextState     = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (status.delayHit) begin
          strobe.cntClr = 1'b1;
          nextState     = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        strobe.cntClr = 1'b1;
        if (wrDone) begin
          strobe.stepAdv = !status.cfgDone;
          strobe.charAdv = status.cfgDone;
          nextState      = ST_ADVANCE;
        end
      end
      ST_ADVANCE: begin
        strobe.cntClr = 1'b1;
        if (status.cfgDone && status.charIsTerm) nextState = ST_FINISHED;
        else                                     nextState = ST_ISSUE;
      end
      default: begin
        strobe.cntClr = 1'b1;
      end
    endcase
  end

  assign panelRstN = (state != ST_PANEL_LOW);
  assign wrReq     = (state == ST_ISSUE);
  assign seqDone   = (state == ST_FINISHED);

endmodule

// File: rtl/lcd_seq_dp.sv
module lcd_seq_dp
  import lcd_seq_pkg::*;
#(
  parameter int                  DELAY_CYCLES = 65025,
  parameter int                  DISP_W       = 256,
  parameter int                  CHAR_W       = 8,
  parameter int                  CHAR_H       = 8,
  parameter int                  DUTY         = 64,
  parameter int                  CURSOR_LINE  = 8,
  parameter bit                  DISPLAY_ON   = 1'b1,
  parameter bit                  MASTER       = 1'b1,
  parameter bit                  BLINK        = 1'b1,
  parameter bit                  CURSOR_ON    = 1'b1,
  parameter bit                  GRAPHICS     = 1'b0,
  parameter bit                  EXT_CG       = 1'b0,
  parameter int                  MSG_LEN      = 6,
  parameter logic [8*MSG_LEN-1:0] MSG         = "READY="
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  output seqStatus_t status,
  output logic [3:0] wrReg,
  output logic [7:0] wrVal
);

  localparam int CNT_W = $clog2(DELAY_CYCLES + 1);
  localparam int IDX_W = $clog2(MSG_LEN + 1);

  localparam logic [7:0] MODE_VAL  = {2'b00, DISPLAY_ON, MASTER, BLINK, CURSOR_ON, GRAPHICS, EXT_CG};
  localparam logic [7:0] PITCH_VAL = {4'(CHAR_H - 1), 4'(CHAR_W - 1)};
  localparam logic [7:0] COLS_VAL  = 8'(DISP_W / CHAR_W - 1);
  localparam logic [7:0] DUTY_VAL  = 8'(DUTY - 1);
  localparam logic [7:0] CURL_VAL  = 8'(CURSOR_LINE - 1);

  logic [CNT_W-1:0] delayCnt;
  logic [3:0]       stepCnt;
  logic [IDX_W-1:0] charIdx;
  logic [7:0]       romByte [MSG_LEN];
  logic [7:0]       curChar;

  for (genvar i = 0; i < MSG_LEN; i++) begin : g_rom
    assign romByte[i] = MSG[8*(MSG_LEN-1-i) +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.cntClr) delayCnt <= '0;
    else                        delayCnt <= delayCnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepCnt <= '0;
      charIdx <= '0;
    end else begin
      if (strobe.stepAdv) stepCnt <= stepCnt + 4'd1;
      if (strobe.charAdv) charIdx <= charIdx + IDX_W'(1);
    end
  end

  // Reading past the end of the message acts as a terminator
  always_comb begin
    curChar = TERM_CHAR;
    for (int i = 0; i < MSG_LEN; i++) begin
      if (charIdx == IDX_W'(i)) curChar = romByte[i];
    end
  end

  always_comb begin
    wrVal = 8'h00;
    unique case (stepCnt)
      4'd0: begin wrReg = REG_MODE;    wrVal = MODE_VAL;  end
      4'd1: begin wrReg = REG_PITCH;   wrVal = PITCH_VAL; end
      4'd2: begin wrReg = REG_COLS;    wrVal = COLS_VAL;  end
      4'd3: begin wrReg = REG_DUTY;    wrVal = DUTY_VAL;  end
      4'd4: begin wrReg = REG_CURLINE; wrVal = CURL_VAL;  end
      4'd5, 4'd6, 4'd7, 4'd8: wrReg = REG_HOME0 + (stepCnt - 4'd5);
      default: begin wrReg = REG_TEXT; wrVal = curChar; end
    endcase
  end

  assign status.delayHit   = (delayCnt == CNT_W'(DELAY_CYCLES - 1));
  assign status.cfgDone    = (stepCnt == 4'(CFG_WRITES));
  assign status.charIsTerm = (curChar == TERM_CHAR);

endmodule

// File: rtl/lcd_startup_seq.sv
module lcd_startup_seq
  import lcd_seq_pkg::*;
#(
  parameter int                  DELAY_CYCLES = 65025,
  parameter int                  DISP_W       = 256,
  parameter int                  CHAR_W       = 8,
  parameter int                  CHAR_H       = 8,
  parameter int                  DUTY         = 64,
  parameter int                  CURSOR_LINE  = 8,
  parameter bit                  DISPLAY_ON   = 1'b1,
  parameter bit                  MASTER       = 1'b1,
  parameter bit                  BLINK        = 1'b1,
  parameter bit                  CURSOR_ON    = 1'b1,
  parameter bit                  GRAPHICS     = 1'b0,
  parameter bit                  EXT_CG       = 1'b0,
  parameter int                  MSG_LEN      = 6,
  parameter logic [8*MSG_LEN-1:0] MSG         = "READY="
) (
  input  logic       clk,
  input  logic       rstN,
  output logic       panelRstN,
  output logic       wrReq,
  output logic [3:0] wrReg,
  output logic [7:0] wrVal,
  input  logic       wrDone,
  output logic       seqDone
);

  seqStrobe_t strobe;
  seqStatus_t status;

  lcd_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrDone    (wrDone),
    .status    (status),
    .strobe    (strobe),
    .panelRstN (panelRstN),
    .wrReq     (wrReq),
    .seqDone   (seqDone)
  );

  lcd_seq_dp #(
    .DELAY_CYCLES (DELAY_CYCLES),
    .DISP_W       (DISP_W),
    .CHAR_W       (CHAR_W),
    .CHAR_H       (CHAR_H),
    .DUTY         (DUTY),
    .CURSOR_LINE  (CURSOR_LINE),
    .DISPLAY_ON   (DISPLAY_ON),
    .MASTER       (MASTER),
    .BLINK        (BLINK),
    .CURSOR_ON    (CURSOR_ON),
    .GRAPHICS     (GRAPHICS),
    .EXT_CG       (EXT_CG),
    .MSG_LEN      (MSG_LEN),
    .MSG          (MSG)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .status (status),
    .wrReg  (wrReg),
    .wrVal  (wrVal)
  );

endmodule

// File: rtl/lcd_startup_seq_chk.sv
module lcd_startup_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       panelRstN,
  input logic       wrReq,
  input logic [3:0] wrReg,
  input logic [7:0] wrVal,
  input logic       wrDone,
  input logic       seqDone
);

  // R1
  panel_stays_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    panelRstN |=> panelRstN);

  // R2
  no_req_in_panel_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    !panelRstN |-> !wrReq);

  // R3
  req_held_until_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && !wrDone) |=> (wrReq && $stable(wrReg) && $stable(wrVal)));

  // R3
  req_drops_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && wrDone) |=> !wrReq);

  // R9
  no_term_written_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && wrReg == 4'd12) |-> (wrVal != 8'h3D));

  // R10
  done_sticky_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |=> (seqDone && !wrReq));

endmodule

bind lcd_startup_seq lcd_startup_seq_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .panelRstN (panelRstN),
  .wrReq     (wrReq),
  .wrReg     (wrReg),
  .wrVal     (wrVal),
  .wrDone    (wrDone),
  .seqDone   (seqDone)
);

// File: tb/lcd_startup_seq_bench.sv
module lcd_startup_seq_rig #(
  parameter int                  DELAY_CYCLES = 20,
  parameter int                  DISP_W       = 256,
  parameter int                  CHAR_W       = 8,
  parameter int                  CHAR_H       = 8,
  parameter int                  DUTY         = 64,
  parameter int                  CURSOR_LINE  = 8,
  parameter bit                  DISPLAY_ON   = 1'b1,
  parameter bit                  MASTER       = 1'b1,
  parameter bit                  BLINK        = 1'b1,
  parameter bit                  CURSOR_ON    = 1'b1,
  parameter bit                  GRAPHICS     = 1'b0,
  parameter bit                  EXT_CG       = 1'b0,
  parameter int                  MSG_LEN      = 6,
  parameter logic [8*MSG_LEN-1:0] MSG         = "READY="
) (
  input logic clk,
  input logic rstN
);

  logic       panelRstN, wrReq, wrDone, seqDone;
  logic [3:0] wrReg;
  logic [7:0] wrVal;

  lcd_startup_seq #(
    .DELAY_CYCLES (DELAY_CYCLES), .DISP_W (DISP_W), .CHAR_W (CHAR_W),
    .CHAR_H (CHAR_H), .DUTY (DUTY), .CURSOR_LINE (CURSOR_LINE),
    .DISPLAY_ON (DISPLAY_ON), .MASTER (MASTER), .BLINK (BLINK),
    .CURSOR_ON (CURSOR_ON), .GRAPHICS (GRAPHICS), .EXT_CG (EXT_CG),
    .MSG_LEN (MSG_LEN), .MSG (MSG)
  ) u_lcd_startup_seq (
    .clk (clk), .rstN (rstN), .panelRstN (panelRstN), .wrReq (wrReq),
    .wrReg (wrReg), .wrVal (wrVal), .wrDone (wrDone), .seqDone (seqDone)
  );

  int         cyc;
  int         nLog, waitN, rstRiseCyc, doneSeenCyc;
  bit         busy, badReq;
  logic [3:0] logReg [32];
  logic [7:0] logVal [32];
  int         reqCyc [32];
  int         doneCyc [32];
  int         checks, errors;

  always @(posedge clk) begin
    if (!rstN) cyc <= 0;
    else       cyc <= cyc + 1;
  end

  // Write engine model with a response delay of 0..3 cycles
  initial wrDone = 1'b0;
  always @(negedge clk) begin
    if (!rstN) begin
      wrDone = 1'b0; busy = 1'b0; nLog = 0; waitN = 0; badReq = 1'b0;
      rstRiseCyc = -1; doneSeenCyc = -1;
    end else begin
      if (panelRstN && rstRiseCyc < 0) rstRiseCyc = cyc;
      if (seqDone && doneSeenCyc < 0) doneSeenCyc = cyc;
      if (wrReq && !panelRstN) badReq = 1'b1;
      if (wrDone) begin
        wrDone = 1'b0;
        busy   = 1'b0;
      end else if (busy) begin
        waitN = waitN - 1;
        if (waitN <= 0) begin
          wrDone = 1'b1;
          doneCyc[nLog-1] = cyc;
        end
      end else if (wrReq && nLog < 32) begin
        logReg[nLog] = wrReg;
        logVal[nLog] = wrVal;
        reqCyc[nLog] = cyc;
        waitN = nLog % 4;
        nLog  = nLog + 1;
        busy  = 1'b1;
        if (waitN == 0) begin
          wrDone = 1'b1;
          doneCyc[nLog-1] = cyc;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] msgByte(input int i);
    return MSG[8*(MSG_LEN-1-i) +: 8];
  endfunction

  task automatic verify();
    logic [3:0] eReg [32];
    logic [7:0] eVal [32];
    int  expN;
    bit  stop;
    eReg[0] = 4'd0; eVal[0] = 8'(32*DISPLAY_ON + 16*MASTER + 8*BLINK + 4*CURSOR_ON + 2*GRAPHICS + EXT_CG);
    eReg[1] = 4'd1; eVal[1] = 8'((CHAR_H - 1) * 16 + (CHAR_W - 1));
    eReg[2] = 4'd2; eVal[2] = 8'(DISP_W / CHAR_W - 1);
    eReg[3] = 4'd3; eVal[3] = 8'(DUTY - 1);
    eReg[4] = 4'd4; eVal[4] = 8'(CURSOR_LINE - 1);
    for (int k = 0; k < 4; k++) begin
      eReg[5+k] = 4'(8 + k);
      eVal[5+k] = 8'h00;
    end
    expN = 9;
    stop = 1'b0;
    for (int i = 0; i < MSG_LEN; i++) begin
      if (msgByte(i) == 8'h3D) stop = 1'b1;
      if (!stop) begin
        eReg[expN] = 4'd12;
        eVal[expN] = msgByte(i);
        expN++;
      end
    end

    chk(rstRiseCyc == DELAY_CYCLES, "R1 panel reset release edge", rstRiseCyc, DELAY_CYCLES);
    chk(reqCyc[0] == 2 * DELAY_CYCLES, "R2 first request edge", reqCyc[0], 2 * DELAY_CYCLES);
    chk(!badReq, "R2 request during panel reset", int'(badReq), 0);
    chk(nLog == expN, "R4 R9 number of writes", nLog, expN);
    for (int i = 0; i < nLog && i < expN; i++) begin
      chk(logReg[i] == eReg[i], "R4 register order", int'(logReg[i]), int'(eReg[i]));
      if (i == 0)      chk(logVal[i] == eVal[i], "R5 mode value", int'(logVal[i]), int'(eVal[i]));
      else if (i == 1) chk(logVal[i] == eVal[i], "R6 pitch value", int'(logVal[i]), int'(eVal[i]));
      else if (i < 5)  chk(logVal[i] == eVal[i], "R7 geometry value", int'(logVal[i]), int'(eVal[i]));
      else if (i < 9)  chk(logVal[i] == eVal[i], "R8 home value", int'(logVal[i]), int'(eVal[i]));
      else             chk(logVal[i] == eVal[i], "R9 text byte", int'(logVal[i]), int'(eVal[i]));
      if (i > 0)
        chk(reqCyc[i] == doneCyc[i-1] + 2, "R3 request spacing", reqCyc[i], doneCyc[i-1] + 2);
    end
    if (nLog > 0)
      chk(doneSeenCyc == doneCyc[nLog-1] + 2, "R10 done timing", doneSeenCyc, doneCyc[nLog-1] + 2);
    chk(seqDone && !wrReq, "R10 done sticky and idle", int'(seqDone), 1);
  endtask

endmodule

module lcd_startup_seq_bench;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 5000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  int   checks = 0, errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Default geometry, five text bytes
  lcd_startup_seq_rig #(.DELAY_CYCLES (20)) u_a (.clk (clk), .rstN (rstN));

  // Alternate geometry and mode bits, terminator mid-message
  lcd_startup_seq_rig #(
    .DELAY_CYCLES (7), .DISP_W (240), .CHAR_W (6), .CHAR_H (10),
    .DUTY (32), .CURSOR_LINE (10), .BLINK (1'b0), .GRAPHICS (1'b1),
    .MSG_LEN (5), .MSG ("AB=CD")
  ) u_b (.clk (clk), .rstN (rstN));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    int waited;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!u_a.panelRstN && !u_b.panelRstN, "R1 panel reset low in reset", int'(u_a.panelRstN), 0);
    chk(!u_a.wrReq && !u_b.wrReq, "R2 no request in reset", int'(u_a.wrReq), 0);
    chk(!u_a.seqDone && !u_b.seqDone, "R10 done low in reset", int'(u_a.seqDone), 0);
    rstN = 1'b1;
    waited = 0;
    while (!(u_a.seqDone && u_b.seqDone) && waited < WATCHDOG) begin
      @(negedge clk);
      waited++;
    end
    if (waited >= WATCHDOG) begin
      chk(1'b0, "R10 watchdog expired", waited, WATCHDOG);
    end else begin
      repeat (12) @(negedge clk);
      u_a.verify();
      u_b.verify();
    end
    checks += u_a.checks + u_b.checks;
    errors += u_a.errors + u_b.errors;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule